// File: doc/BRIEF.md
# Random integer math execution unit

This block runs a short, already-decoded program of register-to-register integer operations over a nine-entry register file of 32-bit words. The four low registers (R0 to R3) are working registers. The five high registers (R4 to R8) are read-only seeds. A start pulse loads all nine registers from external inputs, latches the program length and clears the program counter. The unit then retires one instruction per clock, in address order, from a small instruction memory.

The instruction memory is filled beforehand through a plain write port. Each instruction holds an operation, a 2-bit destination, a 4-bit source and a 32-bit constant. The destination is first operand `a` and the source is `b`. The supported operations are:
- a 32-bit truncating multiply;
- a three-operand add with the constant;
- subtract;
- rotate right and rotate left;
- exclusive-or.

A subtract or exclusive-or whose source is its own destination is refused and flagged. When the program ends, a one-cycle done pulse marks that the four working registers on the result port are final.

Top module: `rmx_unit`

## Requirements
- R1: In the clock after `start` is sampled high, `result[i*32 +: 32]` equals `seed_var[i*32 +: 32]` for R0..R3 and `err` is 0. Register R(4+i) takes `seed_const[i*32 +: 32]`. `start` is honoured even while a program is running, which restarts that program from address 0. After reset, `result`, `busy`, `done` and `err` are all 0.
- R2: While `busy`, exactly one instruction retires per clock. Instructions retire from address 0 upward. Only the working register named by the 2-bit destination is written.
- R3: Opcode 0 writes the low 32 bits of a*b. Opcode 1 writes a+b+imm modulo 2^32. Opcode 2 writes a-b modulo 2^32.
- R4: Opcode 3 writes a rotated right by b[4:0]. Opcode 4 writes a rotated left by b[4:0]. Opcode 5 writes a^b. The constant field is used only by opcode 1.
- R5: Source codes 0 to 8 select R0 to R8. Source codes 9 to 15 read as zero.
- R6: An opcode 2 or opcode 5 instruction whose source code equals its destination leaves its destination unchanged and sets `err`. `err` then stays set until the next `start`.
- R7: Opcodes 6 and 7 retire in their slot with no effect on any register.
- R8: `done` is high for exactly the one cycle that follows the clock edge on which the last instruction writes back, and `busy` is low in that cycle. A length of 0 gives `done` in the cycle after `start`, with the registers left at their seeds.
- R9: Only the first `prog_len` instructions run. The length is latched at `start`, so a later change to `prog_len` has no effect on the running program. Lengths above 69 run 69 instructions.
- R10: While the unit is idle, `result` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we | input | 1 | Instruction memory write strobe |
| ld_addr | input | 7 | Instruction memory write address |
| ld_op | input | 3 | Opcode of the written instruction |
| ld_dst | input | 2 | Destination (R0..R3) of the written instruction |
| ld_src | input | 4 | Source code of the written instruction |
| ld_imm | input | 32 | Constant of the written instruction |
| start | input | 1 | Load seeds, latch length, begin running |
| prog_len | input | 7 | Number of instructions to run |
| seed_var | input | 128 | Initial R0..R3, R0 in the low word |
| seed_const | input | 160 | Values for R4..R8, R4 in the low word |
| busy | output | 1 | Program running |
| done | output | 1 | One-cycle end-of-program pulse |
| err | output | 1 | A self-operand subtract or exclusive-or was refused |
| result | output | 128 | Current R0..R3, R0 in the low word |

## Verification
The first pattern is a random mix of the six operations over all nine sources, with fresh seeds on each run; it separates the arithmetic results from one another and exposes any wrong operand routing. A second pattern uses only rotates and exclusive-or, which catches a rotate with the wrong direction or the wrong amount bits. Further programs use out-of-range sources, the two spare opcodes, and a planted self-operand subtract; each of these shows whether the corresponding instruction is truly inert. Length runs of 0, 1, 69 and an over-long 100 are also tried, together with a length change during a run and a restart partway through a run; these pin down when the program ends and when `done` appears.

// File: rtl/rmx_pkg.sv
package rmx_pkg;
   localparam int XLEN   = 32;
   localparam int NVAR   = 4;
   localparam int NCONST = 5;
   localparam int NREG   = NVAR + NCONST;
   localparam int DST_W  = $clog2(NVAR);
   localparam int SRC_W  = 4;

   typedef enum logic [2:0] {
      OP_MUL  = 3'd0,
      OP_ADD  = 3'd1,
      OP_SUB  = 3'd2,
      OP_ROR  = 3'd3,
      OP_ROL  = 3'd4,
      OP_XOR  = 3'd5,
      OP_NOP6 = 3'd6,
      OP_NOP7 = 3'd7
   } op_e;

   typedef struct packed {
      op_e              op;
      logic [DST_W-1:0] dst;
      logic [SRC_W-1:0] src;
      logic [XLEN-1:0]  imm;
   } instr_t;
endpackage

// File: rtl/rmx_imem.sv
module rmx_imem
   import rmx_pkg::*;
#(
   parameter int DEPTH = 69,
   parameter int AW    = 7
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  instr_t        wdata,
   input  logic [AW-1:0] raddr,
   output instr_t        rdata
);
   instr_t mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we && (int'(waddr) < DEPTH)) mem[waddr] <= wdata;
   end

   assign rdata = (int'(raddr) < DEPTH) ? mem[raddr] : '0;
endmodule

// File: rtl/rmx_regfile.sv
module rmx_regfile
   import rmx_pkg::*;
(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [NVAR*XLEN-1:0]     seed_var,
   input  logic [NCONST*XLEN-1:0]   seed_const,
   input  logic                     we,
   input  logic [DST_W-1:0]         wsel,
   input  logic [XLEN-1:0]          wdata,
   input  logic [DST_W-1:0]         asel,
   input  logic [SRC_W-1:0]         bsel,
   output logic [XLEN-1:0]          a_val,
   output logic [XLEN-1:0]          b_val,
   output logic [NVAR*XLEN-1:0]     var_flat
);
   logic [NREG-1:0][XLEN-1:0] all_regs;

   genvar gi;
   for (gi = 0; gi < NVAR; gi++) begin : g_var
      logic [XLEN-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            q <= '0;
         else if (load)                         q <= seed_var[gi*XLEN +: XLEN];
         else if (we && wsel == DST_W'(gi))     q <= wdata;
      end
      assign all_regs[gi]                 = q;
      assign var_flat[gi*XLEN +: XLEN]    = q;
   end

   for (gi = 0; gi < NCONST; gi++) begin : g_const
      logic [XLEN-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    q <= '0;
         else if (load) q <= seed_const[gi*XLEN +: XLEN];
      end
      assign all_regs[NVAR+gi] = q;
   end

   assign a_val = all_regs[SRC_W'(asel)];
   assign b_val = (int'(bsel) < NREG) ? all_regs[bsel] : '0;
endmodule

// File: rtl/rmx_alu.sv
module rmx_alu
   import rmx_pkg::*;
#(
   parameter int ROT_IMPL = 0
) (
   input  op_e             op,
   input  logic            same,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  logic [XLEN-1:0] imm,
   output logic [XLEN-1:0] y,
   output logic            wr,
   output logic            illegal
);
   localparam int SH_W = $clog2(XLEN);

   logic [SH_W-1:0] amt;
   logic [XLEN-1:0] rot_r, rot_l;

   assign amt = b[SH_W-1:0];

   if (ROT_IMPL == 0) begin : g_rot_shift
      logic [2*XLEN-1:0] dbl, rr, rl;
      assign dbl   = {a, a};
      assign rr    = dbl >> amt;
      assign rl    = dbl << amt;
      assign rot_r = rr[XLEN-1:0];
      assign rot_l = rl[2*XLEN-1:XLEN];
   end else begin : g_rot_mux
      always_comb begin
         for (int i = 0; i < XLEN; i++) begin
            rot_r[i] = a[SH_W'((i + int'(amt)) % XLEN)];
            rot_l[i] = a[SH_W'((i - int'(amt) + XLEN) % XLEN)];
         end
      end
   end

   assign illegal = ((op == OP_SUB) || (op == OP_XOR)) && same;
   assign wr      = (op != OP_NOP6) && (op != OP_NOP7) && !illegal;

   always_comb begin
      unique case (op)
         OP_MUL:  y = a * b;
         OP_ADD:  y = a + b + imm;
         OP_SUB:  y = a - b;
         OP_ROR:  y = rot_r;
         OP_ROL:  y = rot_l;
         OP_XOR:  y = a ^ b;
         default: y = a;
      endcase
   end
endmodule

// File: rtl/rmx_unit.sv
module rmx_unit
   import rmx_pkg::*;
#(
   parameter int DEPTH    = 69,
   parameter int LEN_W    = 7,
   parameter int ROT_IMPL = 0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ld_we,
   input  logic [LEN_W-1:0]       ld_addr,
   input  logic [2:0]             ld_op,
   input  logic [DST_W-1:0]       ld_dst,
   input  logic [SRC_W-1:0]       ld_src,
   input  logic [XLEN-1:0]        ld_imm,
   input  logic                   start,
   input  logic [LEN_W-1:0]       prog_len,
   input  logic [NVAR*XLEN-1:0]   seed_var,
   input  logic [NCONST*XLEN-1:0] seed_const,
   output logic                   busy,
   output logic                   done,
   output logic                   err,
   output logic [NVAR*XLEN-1:0]   result
);
   initial begin : elab_checks
      assert (DEPTH >= 1 && DEPTH < (1 << LEN_W))
         else $error("rmx_unit: DEPTH must fit the length field");
      assert ((XLEN & (XLEN - 1)) == 0)
         else $error("rmx_unit: XLEN must be a power of two");
      assert (ROT_IMPL == 0 || ROT_IMPL == 1)
         else $error("rmx_unit: ROT_IMPL must be 0 or 1");
   end

   instr_t           wr_ins, cur_ins;
   logic [LEN_W-1:0] pc_q, len_q, len_clamp;
   logic             busy_q, done_q, err_q;
   logic [XLEN-1:0]  a_val, b_val, alu_y;
   logic             alu_wr, alu_illegal, rf_we;

   assign wr_ins = '{op: op_e'(ld_op), dst: ld_dst, src: ld_src, imm: ld_imm};

   rmx_imem #(.DEPTH(DEPTH), .AW(LEN_W)) imem_i (
      .clk(clk), .we(ld_we), .waddr(ld_addr), .wdata(wr_ins),
      .raddr(pc_q), .rdata(cur_ins)
   );

   assign rf_we = busy_q && !start && alu_wr;

   rmx_regfile regs_i (
      .clk(clk), .rst_n(rst_n), .load(start),
      .seed_var(seed_var), .seed_const(seed_const),
      .we(rf_we), .wsel(cur_ins.dst), .wdata(alu_y),
      .asel(cur_ins.dst), .bsel(cur_ins.src),
      .a_val(a_val), .b_val(b_val), .var_flat(result)
   );

   rmx_alu #(.ROT_IMPL(ROT_IMPL)) alu_i (
      .op(cur_ins.op), .same(cur_ins.src == SRC_W'(cur_ins.dst)),
      .a(a_val), .b(b_val), .imm(cur_ins.imm),
      .y(alu_y), .wr(alu_wr), .illegal(alu_illegal)
   );

   assign len_clamp = (int'(prog_len) > DEPTH) ? LEN_W'(DEPTH) : prog_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q   <= '0;
         len_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            pc_q   <= '0;
            len_q  <= len_clamp;
            busy_q <= (len_clamp != '0);
            done_q <= (len_clamp == '0);
            err_q  <= 1'b0;
         end else if (busy_q) begin
            pc_q <= pc_q + 1'b1;
            if (alu_illegal) err_q <= 1'b1;
            if (pc_q == len_q - 1'b1) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign busy = busy_q;
   assign done = done_q;
   assign err  = err_q;
endmodule

// File: rtl/rmx_chk.sv
module rmx_chk
   import rmx_pkg::*;
(
   input logic                 clk,
   input logic                 rst_n,
   input logic                 start,
   input logic                 busy,
   input logic                 done,
   input logic                 err,
   input logic [NVAR*XLEN-1:0] result,
   input logic [2:0]           cur_op,
   input logic [DST_W-1:0]     cur_dst,
   input logic [SRC_W-1:0]     cur_src
);
   logic self_op;
   assign self_op = busy && !start && (cur_op == 3'd2 || cur_op == 3'd5) &&
                    (cur_src == SRC_W'(cur_dst));

   assert_start_response_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> ((busy || done) && !err));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !done);

   assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   assert_no_busy_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_self_op_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      self_op |=> err);

   assert_self_op_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      self_op |=> (result == $past(result)));

   assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !start) |=> err);

   assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(result));
endmodule

bind rmx_unit rmx_chk chk_i (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .err(err), .result(result), .cur_op(cur_ins.op), .cur_dst(cur_ins.dst),
   .cur_src(cur_ins.src)
);

// File: tb/rmx_unit_tb_top.sv
module rmx_unit_tb_top;
   localparam int DEPTH = 69;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ld_we = 1'b0;
   logic [6:0]   ld_addr = '0;
   logic [2:0]   ld_op = '0;
   logic [1:0]   ld_dst = '0;
   logic [3:0]   ld_src = '0;
   logic [31:0]  ld_imm = '0;
   logic         start = 1'b0;
   logic [6:0]   prog_len = '0;
   logic [127:0] seed_var = '0;
   logic [159:0] seed_const = '0;
   logic         busy, done, err;
   logic [127:0] result;

   always #4 clk = ~clk;

   rmx_unit dut_i (
      .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_op(ld_op),
      .ld_dst(ld_dst), .ld_src(ld_src), .ld_imm(ld_imm), .start(start),
      .prog_len(prog_len), .seed_var(seed_var), .seed_const(seed_const),
      .busy(busy), .done(done), .err(err), .result(result)
   );

   // behavioural reference
   logic [31:0] m_r [9];
   int          m_op [DEPTH];
   int          m_dst [DEPTH];
   int          m_src [DEPTH];
   logic [31:0] m_imm [DEPTH];
   int          m_pc, m_len;
   bit          m_busy, m_done, m_err;

   int    total = 0, bad = 0;
   string phase = "R1";

   function automatic logic [31:0] rotr(logic [31:0] v, int k);
      if (k == 0) return v;
      return (v >> k) | (v << (32 - k));
   endfunction

   task automatic m_exec(int p);
      logic [31:0] a, b;
      int d, s;
      d = m_dst[p];
      s = m_src[p];
      a = m_r[d];
      b = (s <= 8) ? m_r[s] : 32'd0;
      if ((m_op[p] == 2 || m_op[p] == 5) && s == d) begin
         m_err = 1'b1;
      end else begin
         case (m_op[p])
            0: m_r[d] = a * b;
            1: m_r[d] = a + b + m_imm[p];
            2: m_r[d] = a - b;
            3: m_r[d] = rotr(a, int'(b[4:0]));
            4: m_r[d] = rotr(a, (32 - int'(b[4:0])) % 32);
            5: m_r[d] = a ^ b;
            default: ;
         endcase
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 9; i++) m_r[i] = '0;
         m_pc = 0; m_len = 0; m_busy = 0; m_done = 0; m_err = 0;
      end else begin
         m_done = 0;
         if (start) begin
            for (int i = 0; i < 4; i++) m_r[i] = seed_var[i*32 +: 32];
            for (int i = 0; i < 5; i++) m_r[4+i] = seed_const[i*32 +: 32];
            m_pc = 0;
            m_len = (int'(prog_len) > DEPTH) ? DEPTH : int'(prog_len);
            m_err = 0;
            m_busy = (m_len != 0);
            m_done = (m_len == 0);
         end else if (m_busy) begin
            m_exec(m_pc);
            m_pc++;
            if (m_pc == m_len) begin
               m_busy = 0;
               m_done = 1;
            end
         end
         if (ld_we && int'(ld_addr) < DEPTH) begin
            m_op[ld_addr]  = int'(ld_op);
            m_dst[ld_addr] = int'(ld_dst);
            m_src[ld_addr] = int'(ld_src);
            m_imm[ld_addr] = ld_imm;
         end
      end
   end

   task automatic check(bit ok, string what, logic [127:0] act, logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", phase, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         logic [127:0] expv;
         for (int i = 0; i < 4; i++) expv[i*32 +: 32] = m_r[i];
         check(result == expv, "result", result, expv);
         check(busy == m_busy, "busy", 128'(busy), 128'(m_busy));
         check(done == m_done, "done", 128'(done), 128'(m_done));
         check(err == m_err, "err", 128'(err), 128'(m_err));
      end
   end

   task automatic write_ins(int addr, int op, int dst, int src, logic [31:0] imm);
      ld_we = 1'b1;
      ld_addr = 7'(addr);
      ld_op = 3'(op);
      ld_dst = 2'(dst);
      ld_src = 4'(src);
      ld_imm = imm;
      @(negedge clk);
   endtask

   // mode 0 mix, 1 rotate/xor, 2 high sources, 3 planted self-op, 4 spare opcodes
   task automatic fill(int n, int mode);
      for (int i = 0; i < n; i++) begin
         int op, dst, src;
         logic [31:0] imm;
         op  = $urandom_range(5);
         dst = $urandom_range(3);
         src = $urandom_range(8);
         imm = $urandom;
         if (mode == 1) op = 3 + $urandom_range(2);
         if (mode == 2) src = 9 + $urandom_range(6);
         if (mode == 4 && (i % 3) == 0) op = 6 + $urandom_range(1);
         if ((op == 2 || op == 5) && src == dst) src = dst + 4;
         if (mode == 3 && i == 5) begin
            op = 2;
            src = dst;
         end
         write_ins(i, op, dst, src, imm);
      end
      ld_we = 1'b0;
   endtask

   task automatic kick(int len);
      seed_var = {$urandom, $urandom, $urandom, $urandom};
      seed_const = {$urandom, $urandom, $urandom, $urandom, $urandom};
      prog_len = 7'(len);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic finish_run();
      while (m_busy || m_done) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      phase = "R1";
      @(negedge clk);
      check(result == '0 && !busy && !done && !err, "reset state", result, '0);

      phase = "R2/R3";
      for (int k = 0; k < 6; k++) begin
         fill(69, 0);
         kick(60 + k);
         finish_run();
      end

      phase = "R4";
      for (int k = 0; k < 4; k++) begin
         fill(64, 1);
         kick(64);
         finish_run();
      end

      phase = "R5";
      fill(40, 2);
      kick(40);
      finish_run();

      phase = "R6";
      fill(20, 3);
      kick(20);
      finish_run();
      check(err == 1'b1, "err after self-op", 128'(err), 128'd1);
      kick(20);
      check(err == 1'b0, "err cleared by start", 128'(err), 128'd0);
      finish_run();

      phase = "R7";
      fill(30, 4);
      kick(30);
      finish_run();

      phase = "R8";
      kick(0);
      check(done == 1'b1 && result == seed_var, "zero length", result, seed_var);
      finish_run();
      fill(1, 0);
      kick(1);
      finish_run();

      phase = "R9";
      fill(69, 0);
      kick(100);
      prog_len = 7'd3;
      finish_run();
      kick(10);
      prog_len = 7'd50;
      finish_run();

      phase = "R1";
      kick(69);
      repeat (10) @(negedge clk);
      kick(20);
      finish_run();

      phase = "R10";
      repeat (20) @(negedge clk);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule